// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Flags

This block is a two-clock first-in first-out buffer for fixed-width words. Writers push words on the write clock and readers pull them on the read clock. Read and write pointers cross between the clock domains as Gray code. The block runs in one of two timing modes, chosen by a mode input that is sampled while reset is held. In request mode the output bus changes only when a read is requested. In fall-through mode the oldest word is copied to the output bus without a request. A later read enable consumes that word, and the next stored word then takes its place.

The mode sets the polarity and meaning of the two main status pins. It also shifts every occupancy threshold by one in fall-through mode, because the output register then holds one extra word. The almost-empty offset and the almost-full offset come from static input ports. Half-full and almost-full are computed in the write clock domain. Almost-empty is computed in the read clock domain.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode input is sampled only while `rst_ni` is low: 0 selects request mode and 1 selects fall-through mode. Changing the mode input after reset has no effect on behaviour.
- R2: In request mode, `empty_flag_o` is 0 while no word is stored and 1 once at least one word is stored. `full_flag_o` is 1 until DEPTH words are stored, then 0. `dout_o` changes only after a read-clock edge on which `ren_ni` is 0 and the FIFO is not empty.
- R3: In fall-through mode, `empty_flag_o` is 0 exactly when a valid head word is on `dout_o`. That head word appears without `ren_ni` being asserted. A read consumes it, and the next stored word replaces it.
- R4: In fall-through mode, `full_flag_o` is 0 until DEPTH+1 words are held, then 1.
- R5: With k words held and offset n, `pae_no` is 1 when k > n in request mode and when k > n+1 in fall-through mode. Otherwise it is 0.
- R6: `half_no` is 0 when k >= DEPTH/2+1 in request mode, or k >= DEPTH/2+2 in fall-through mode. Otherwise it is 1.
- R7: With offset m, `paf_no` is 0 when k >= DEPTH-m in request mode, or k >= DEPTH+1-m in fall-through mode. Otherwise it is 1.
- R8: A read from a full FIFO clears the full indication. A read requested while the FIFO is empty leaves `dout_o` and all flags unchanged.
- R9: A write attempted while full is dropped. No stored word and no count changes.
- R10: While reset is low, `dout_o` is cleared to zero and all flags take their empty-FIFO values for the selected mode.
- R11: Words leave in the order they were written, including across pointer wrap-around.
- R12: The occupancy that either clock domain computes from its synchronized view of the other pointer never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| fwft_i | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| wen_ni | input | 1 | Write enable, active low |
| din_i | input | WIDTH | Write data |
| ren_ni | input | 1 | Read enable, active low |
| dout_o | output | WIDTH | Read data |
| empty_off_i | input | AW-1 | Almost-empty offset n |
| full_off_i | input | AW-1 | Almost-full offset m |
| empty_flag_o | output | 1 | Request mode: not-empty (high = data stored); fall-through mode: output-not-ready (low = head valid) |
| full_flag_o | output | 1 | Request mode: not-full (low = full); fall-through mode: input-blocked (high = full) |
| half_no | output | 1 | Half-full, active low |
| pae_no | output | 1 | Programmable almost-empty, active low |
| paf_no | output | 1 | Programmable almost-full, active low |

## Verification
The bench fills the FIFO one word at a time in each mode and then drains it. After every step it compares all five flags against thresholds derived from the held count. An off-by-one between the modes would therefore move a flag one word early or late. A design that ignored the extra output-register word would report full after DEPTH words in fall-through mode instead of DEPTH+1. The bench also writes into a full FIFO and reads from an empty one. An unguarded pointer would then show an extra word, or lose the last one, in the drained sequence. A second fill and drain without reset forces pointer wrap-around. Flipping the mode input after reset shows any design that keeps sampling it, because data would fall through, or fail to, on the wrong side.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_REQ  = 1'b0,
    MODE_FALL = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dmf_ptr_sync.sv
module dmf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int WIDTH = 16,
  parameter int AW    = 4
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl
  import dmf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int OW    = 3
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wen_ni,
  input  logic [OW-1:0] full_off_i,
  input  logic [AW:0]   rbin_i,
  output logic          push_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_flag_o,
  output logic          half_no,
  output logic          paf_no
);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  fifo_mode_e    mode_q;
  logic [PW-1:0] wbin_q, wbin_nx, occ_nx, wgray_q, paf_lvl;
  logic          full_q, hf_n_q, paf_n_q;

  // mode captured only while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_i);
  end

  assign push_o  = !wen_ni && !full_q;
  assign wbin_nx = wbin_q + PW'(push_o);
  assign occ_nx  = wbin_nx - rbin_i;
  assign paf_lvl = PW'(DEPTH) - PW'(full_off_i);

  // thresholds act on RAM occupancy; fall-through offset comes from the output word
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      hf_n_q  <= 1'b1;
      paf_n_q <= 1'b1;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      full_q  <= (occ_nx == PW'(DEPTH));
      hf_n_q  <= !(occ_nx >= PW'(HALF + 1));
      paf_n_q <= !(occ_nx >= paf_lvl);
    end
  end

  assign waddr_o     = wbin_q[AW-1:0];
  assign wgray_o     = wgray_q;
  assign full_flag_o = (mode_q == MODE_FALL) ? full_q : !full_q;
  assign half_no     = hf_n_q;
  assign paf_no      = paf_n_q;

  logic [PW-1:0] occ_now;
  assign occ_now = wbin_q - rbin_i;

  AST_WR_OCC_BOUND: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    occ_now <= PW'(DEPTH)); // R12
  AST_FULL_HOLDS_PTR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_q && !wen_ni && $stable(rbin_i) |=> $stable(wbin_q)); // R9
  AST_FULL_IMPLIES_PAF: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_q |-> !paf_n_q); // R7
  AST_PAF_IMPLIES_HF: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !paf_n_q |-> !hf_n_q); // R6
  AST_WR_MODE_HELD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q)); // R1
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
  import dmf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int OW    = 3
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             fwft_i,
  input  logic             ren_ni,
  input  logic [OW-1:0]    empty_off_i,
  input  logic [AW:0]      wbin_i,
  input  logic [WIDTH-1:0] rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [AW:0]      rgray_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_flag_o,
  output logic             pae_no
);
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;

  fifo_mode_e       mode_q;
  logic [PW-1:0]    rbin_q, rbin_nx, rgray_q, occ_nx;
  logic [CW-1:0]    held_nx, pae_lvl;
  logic [WIDTH-1:0] dout_q;
  logic             ram_empty_q, ov_q, ov_nx, pop;

  always_ff @(posedge rclk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_i);
  end

  // fall-through prefetches whenever the output word is free or being consumed
  always_comb begin
    if (mode_q == MODE_FALL) begin
      pop   = !ram_empty_q && (!ov_q || !ren_ni);
      ov_nx = pop ? 1'b1 : (!ren_ni ? 1'b0 : ov_q);
    end else begin
      pop   = !ren_ni && !ram_empty_q;
      ov_nx = 1'b0;
    end
  end

  assign rbin_nx = rbin_q + PW'(pop);
  assign occ_nx  = wbin_i - rbin_nx;
  assign held_nx = CW'(occ_nx) + CW'(ov_nx);
  assign pae_lvl = CW'(empty_off_i) + ((mode_q == MODE_FALL) ? CW'(1) : CW'(0));

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q      <= '0;
      rgray_q     <= '0;
      ram_empty_q <= 1'b1;
      ov_q        <= 1'b0;
      dout_q      <= '0;
      pae_n_q     <= 1'b0;
    end else begin
      rbin_q      <= rbin_nx;
      rgray_q     <= rbin_nx ^ (rbin_nx >> 1);
      ram_empty_q <= (occ_nx == '0);
      ov_q        <= ov_nx;
      pae_n_q     <= (held_nx > pae_lvl);
      if (pop) dout_q <= rdata_i;
    end
  end

  logic pae_n_q;

  assign raddr_o      = rbin_q[AW-1:0];
  assign rgray_o      = rgray_q;
  assign dout_o       = dout_q;
  assign empty_flag_o = (mode_q == MODE_FALL) ? !ov_q : !ram_empty_q;
  assign pae_no       = pae_n_q;

  logic [PW-1:0] occ_now;
  assign occ_now = wbin_i - rbin_q;

  AST_RD_OCC_BOUND: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    occ_now <= PW'(DEPTH)); // R12
  AST_REQ_EMPTY_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_q == MODE_REQ) && ram_empty_q |=> $stable(dout_q)); // R8
  AST_FALL_HEAD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_q == MODE_FALL) && ov_q && ren_ni |=> ov_q && $stable(dout_q)); // R3
  AST_RD_MODE_HELD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q)); // R1
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = AW - 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             fwft_i,
  input  logic             wen_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             ren_ni,
  output logic [WIDTH-1:0] dout_o,
  input  logic [OW-1:0]    empty_off_i,
  input  logic [OW-1:0]    full_off_i,
  output logic             empty_flag_o,
  output logic             full_flag_o,
  output logic             half_no,
  output logic             pae_no,
  output logic             paf_no
);
  logic             push;
  logic [AW-1:0]    waddr, raddr;
  logic [AW:0]      wgray, rgray, wbin_rs, rbin_ws;
  logic [WIDTH-1:0] rdata;

  dmf_mem #(.WIDTH(WIDTH), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (push),
    .waddr_i(waddr),
    .wdata_i(din_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  dmf_ptr_sync #(.W(AW + 1)) u_rptr_to_w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rgray),
    .bin_o (rbin_ws)
  );

  dmf_ptr_sync #(.W(AW + 1)) u_wptr_to_r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray),
    .bin_o (wbin_rs)
  );

  dmf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .OW(OW)) u_wr (
    .wclk_i     (wclk_i),
    .rst_ni     (rst_ni),
    .fwft_i     (fwft_i),
    .wen_ni     (wen_ni),
    .full_off_i (full_off_i),
    .rbin_i     (rbin_ws),
    .push_o     (push),
    .waddr_o    (waddr),
    .wgray_o    (wgray),
    .full_flag_o(full_flag_o),
    .half_no    (half_no),
    .paf_no     (paf_no)
  );

  dmf_rd_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .OW(OW)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .fwft_i      (fwft_i),
    .ren_ni      (ren_ni),
    .empty_off_i (empty_off_i),
    .wbin_i      (wbin_rs),
    .rdata_i     (rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .dout_o      (dout_o),
    .empty_flag_o(empty_flag_o),
    .pae_no      (pae_no)
  );
endmodule

// File: tb/dual_mode_fifo_tb_top.sv
module dual_mode_fifo_tb_top;
  localparam int W  = 16;
  localparam int D  = 16;
  localparam int OW = $clog2(D) - 1;
  localparam int N  = 3;
  localparam int M  = 4;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          rst_ni = 1'b0, fwft = 1'b0, wen_n = 1'b1, ren_n = 1'b1;
  logic [W-1:0]  din = '0, dout;
  logic          ef, ff, hf_n, pae_n, paf_n;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end

  dual_mode_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .fwft_i(fwft),
    .wen_ni(wen_n), .din_i(din), .ren_ni(ren_n), .dout_o(dout),
    .empty_off_i(OW'(N)), .full_off_i(OW'(M)),
    .empty_flag_o(ef), .full_flag_o(ff), .half_no(hf_n),
    .pae_no(pae_n), .paf_no(paf_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic do_reset(input bit f);
    rst_ni = 1'b0;
    fwft   = f;
    repeat (4) @(negedge wclk);
    rst_ni = 1'b1;
    settle();
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge wclk);
    wen_n = 1'b0;
    din   = d;
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic rd();
    @(negedge rclk);
    ren_n = 1'b0;
    @(negedge rclk);
    ren_n = 1'b1;
  endtask

  // expected flag pins for k held words
  task automatic check_flags(input int k, input bit f);
    if (!f) begin
      chk("R2 empty flag", ef, k > 0);
      chk("R2 full flag", ff, !(k >= D));
      chk("R5 almost-empty", pae_n, k > N);
      chk("R6 half-full", hf_n, !(k >= D/2 + 1));
      chk("R7 almost-full", paf_n, !(k >= D - M));
    end else begin
      chk("R3 output-ready", ef, !(k > 0));
      chk("R4 input-ready", ff, k >= D + 1);
      chk("R5 almost-empty", pae_n, k > N + 1);
      chk("R6 half-full", hf_n, !(k >= D/2 + 2));
      chk("R7 almost-full", paf_n, !(k >= D + 1 - M));
    end
  endtask

  function automatic logic [W-1:0] word(input bit f, input int r, input int i);
    return 16'hA000 ^ (W'(f) << 12) ^ (W'(r) << 8) ^ W'(i);
  endfunction

  task automatic run_mode(input bit f);
    int cap;
    logic [W-1:0] held;
    cap = f ? D + 1 : D;
    do_reset(f);
    chk("R10 reset dout", dout, 0);
    check_flags(0, f);
    fwft = !f;  // must be ignored after reset
    for (int r = 0; r < 2; r++) begin
      wr(word(f, r, 0));
      settle();
      check_flags(1, f);
      if (r == 0) begin
        if (!f) chk("R1 R2 no read without enable", dout, 0);
        else    chk("R1 R3 head falls through", dout, word(f, r, 0));
      end
      for (int i = 1; i < cap; i++) begin
        wr(word(f, r, i));
        settle();
        check_flags(i + 1, f);
      end
      wr(16'hFFFF);
      settle();
      check_flags(cap, f);  // R9
      for (int i = 0; i < cap; i++) begin
        if (f) chk("R3 R11 head word", dout, word(f, r, i));
        rd();
        settle();
        if (!f) chk("R2 R11 read word", dout, word(f, r, i));
        check_flags(cap - 1 - i, f);  // i==0 covers R8 full release
      end
      held = dout;
      rd();
      settle();
      chk("R8 read on empty keeps dout", dout, held);
      check_flags(0, f);
      chk("R9 dropped word absent", dout == 16'hFFFF, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule